// File: doc/BRIEF.md
# Saturating Fixed-Point Arithmetic Coprocessor

This block is a scalar coprocessor that sits beside a RISC core and executes the fixed-point primitives that speech codecs use most: saturating 16-bit and 32-bit add and subtract, 32-to-16 clamping, fractional 16x16 multiplies and saturating multiply-accumulate and multiply-subtract. It keeps a private bank of sixteen 32-bit registers and one sticky overflow flag. The host reaches both only through move commands.

The host presents one decoded command per clock. Each command carries an opcode, a destination register, two source registers and a 32-bit host value. Commands pass through three stages. The first reads the register file and captures operands with write-through bypass. The second applies late forwarding and runs the 16x16 signed multiply. The third does the 32-bit add or subtract, saturation, the flag update and the writeback. A command that reads a register or the flag drives the value back on a 32-bit result port together with a one-cycle valid pulse. The commands execute in strict program order with no stall, so a command can consume the result of the command issued on the previous cycle.

Top module: `dspc_core`

## Requirements
- R1: After reset, all sixteen registers read as zero, the overflow flag reads as zero, `res_valid` is low and `res_data` is zero.
- R2: Opcode 1 writes `host_data` into register `cmd_dst`. Opcode 2 returns register `cmd_src_a` on `res_data` with `res_valid` high for one cycle. That cycle follows the third rising edge, counting the edge that samples the command.
- R3: Opcode 3 loads bit 0 of `host_data` into the overflow flag. Opcode 4 returns the flag in bit 0 of `res_data`, with bits 31:1 zero and the same timing as R2.
- R4: Opcode 5 clamps the signed 32-bit value of `cmd_src_a` to the range -32768..32767 and writes the result sign-extended to `cmd_dst`. It raises the flag when it clamps.
- R5: Opcodes 6 and 7 add and subtract the signed low halves (bits 15:0) of `cmd_src_a` and `cmd_src_b`. The result is clamped to 0x7FFF or 0x8000 and written sign-extended.
- R6: Opcodes 8 and 9 add and subtract the full 32-bit values. On overflow the result clamps to 0x7FFFFFFF or 0x80000000.
- R7: Opcode 10 takes the low-half product shifted right arithmetically by 15. The result is clamped to 16 bits and written sign-extended, so -32768 times -32768 gives 0x00007FFF and raises the flag.
- R8: Opcode 11 writes twice the signed low-half product. -32768 times -32768 gives 0x7FFFFFFF and raises the flag.
- R9: Opcode 12 writes the 32-bit saturating sum of register `cmd_dst` and the opcode-11 product of the sources. Opcode 13 subtracts that product instead. Either saturation raises the flag.
- R10: The flag is sticky. Any clamping sets it, and it stays set through later non-clamping operations until opcode 14 clears it. Opcode 15 sets it.
- R11: Commands issued on consecutive cycles behave exactly as if each had completed before the next. This holds for dependent chains of every opcode, including multiply-accumulate.
- R12: Opcodes 0, 1, 3 and 5 to 15 never raise `res_valid`. Whenever `res_valid` is low, `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode (encoding in R2 to R10; 0 is no-op) |
| cmd_dst | input | 4 | Destination register, also the accumulator for opcodes 12 and 13 |
| cmd_src_a | input | 4 | First source register |
| cmd_src_b | input | 4 | Second source register |
| host_data | input | 32 | Host register value for opcodes 1 and 3 |
| res_valid | output | 1 | One-cycle pulse marking a returned value |
| res_data | output | 32 | Returned register or flag value |

## Verification
A read command sampled at edge n shows its value on the result port after edge n+2. A register or flag change made by any command is visible to a read that is sampled at edge n+1 or later. The bench keeps a sequential reference model that is updated at each sampling edge. It pushes the expected port value into a three-deep delay line and compares the port against the oldest slot at every falling edge. The result port is therefore checked on every cycle, including the idle cycles and the cycles that follow non-read commands.

// File: rtl/dspc_pkg.sv
package dspc_pkg;
    localparam int DW   = 32;
    localparam int HW   = 16;
    localparam int NREG = 16;
    localparam int AW   = $clog2(NREG);
    localparam int NRD  = 3;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_WR_REG   = 4'd1,
        OP_RD_REG   = 4'd2,
        OP_WR_FLAG  = 4'd3,
        OP_RD_FLAG  = 4'd4,
        OP_SAT16    = 4'd5,
        OP_ADD16    = 4'd6,
        OP_SUB16    = 4'd7,
        OP_ADD32    = 4'd8,
        OP_SUB32    = 4'd9,
        OP_MUL16    = 4'd10,
        OP_MUL32    = 4'd11,
        OP_MAC      = 4'd12,
        OP_MSU      = 4'd13,
        OP_CLR_FLAG = 4'd14,
        OP_SET_FLAG = 4'd15
    } op_e;

    // operands captured at the end of the read stage
    typedef struct packed {
        logic            valid;
        op_e             op;
        logic [AW-1:0]   dst;
        logic [AW-1:0]   src_a;
        logic [AW-1:0]   src_b;
        logic [DW-1:0]   a;
        logic [DW-1:0]   b;
        logic [DW-1:0]   c;
    } x1_t;

    // forwarded operands plus raw product, entering the final stage
    typedef struct packed {
        logic            valid;
        op_e             op;
        logic [AW-1:0]   dst;
        logic [DW-1:0]   a;
        logic [DW-1:0]   b;
        logic [DW-1:0]   c;
        logic [DW-1:0]   prod;
    } x2_t;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          ovf;
    } sat_t;

    localparam logic signed [DW:0] HALF_MAX = $signed({{(DW-HW+2){1'b0}}, {(HW-1){1'b1}}});
    localparam logic signed [DW:0] HALF_MIN = ~HALF_MAX;
    localparam logic signed [DW:0] FULL_MAX = $signed({2'b00, {(DW-1){1'b1}}});
    localparam logic signed [DW:0] FULL_MIN = ~FULL_MAX;
    localparam logic [DW-1:0]      PROD_EDGE = {2'b01, {(DW-2){1'b0}}};

    function automatic logic signed [DW:0] ext_half(logic [HW-1:0] v);
        return $signed({{(DW-HW+1){v[HW-1]}}, v});
    endfunction

    function automatic logic signed [DW:0] ext_full(logic [DW-1:0] v);
        return $signed({v[DW-1], v});
    endfunction

    function automatic sat_t clamp_half(logic signed [DW:0] v);
        sat_t r;
        if (v > HALF_MAX)      r = '{val: HALF_MAX[DW-1:0], ovf: 1'b1};
        else if (v < HALF_MIN) r = '{val: HALF_MIN[DW-1:0], ovf: 1'b1};
        else                   r = '{val: v[DW-1:0], ovf: 1'b0};
        return r;
    endfunction

    function automatic sat_t clamp_full(logic signed [DW:0] v);
        sat_t r;
        if (v > FULL_MAX)      r = '{val: FULL_MAX[DW-1:0], ovf: 1'b1};
        else if (v < FULL_MIN) r = '{val: FULL_MIN[DW-1:0], ovf: 1'b1};
        else                   r = '{val: v[DW-1:0], ovf: 1'b0};
        return r;
    endfunction

    function automatic logic uses_host(op_e op);
        return (op == OP_WR_REG) || (op == OP_WR_FLAG);
    endfunction
endpackage

// File: rtl/dspc_regfile.sv
module dspc_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    parameter int NRD  = 3,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // each read port sees a write landing on the same edge
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (we && (waddr == raddr[p])) ? wdata : mem_q[raddr[p]];
    end
endmodule

// File: rtl/dspc_exec1.sv
module dspc_exec1
    import dspc_pkg::*;
(
    input  x1_t            x1,
    input  logic           fwd_en,
    input  logic [AW-1:0]  fwd_dst,
    input  logic [DW-1:0]  fwd_data,
    output x2_t            x2
);
    logic [DW-1:0]        a_fix, b_fix, c_fix;
    logic signed [HW-1:0] a_h, b_h;
    logic signed [DW-1:0] prod;
    logic                 rf_src;

    always_comb begin
        // the command one stage ahead writes late: pick up its result here
        rf_src = !uses_host(x1.op);
        a_fix  = (rf_src && fwd_en && fwd_dst == x1.src_a) ? fwd_data : x1.a;
        b_fix  = (fwd_en && fwd_dst == x1.src_b) ? fwd_data : x1.b;
        c_fix  = (fwd_en && fwd_dst == x1.dst)   ? fwd_data : x1.c;
        a_h    = $signed(a_fix[HW-1:0]);
        b_h    = $signed(b_fix[HW-1:0]);
        prod   = a_h * b_h;
        x2     = '{valid: x1.valid, op: x1.op, dst: x1.dst,
                   a: a_fix, b: b_fix, c: c_fix, prod: prod};
    end
endmodule

// File: rtl/dspc_exec2.sv
module dspc_exec2
    import dspc_pkg::*;
(
    input  x2_t            x2,
    input  logic           ovf_q,
    output logic           wb_en,
    output logic [DW-1:0]  wb_data,
    output logic           rd_en,
    output logic [DW-1:0]  rd_data,
    output logic           ovf_d
);
    logic [DW-1:0]        dbl_val;
    logic                 dbl_ovf;
    logic signed [DW-1:0] shr_prod;
    sat_t                 sr;
    logic                 hit;

    always_comb begin
        dbl_ovf  = (x2.prod == PROD_EDGE);
        dbl_val  = dbl_ovf ? FULL_MAX[DW-1:0] : (x2.prod << 1);
        shr_prod = $signed(x2.prod) >>> (HW-1);
        wb_en    = 1'b0;
        wb_data  = x2.a;
        rd_en    = 1'b0;
        rd_data  = '0;
        sr       = '{val: '0, ovf: 1'b0};
        hit      = 1'b0;
        ovf_d    = ovf_q;
        unique case (x2.op)
            OP_WR_REG:   wb_en = 1'b1;
            OP_RD_REG:   begin rd_en = 1'b1; rd_data = x2.a; end
            OP_WR_FLAG:  ovf_d = x2.a[0];
            OP_RD_FLAG:  begin rd_en = 1'b1; rd_data = {{(DW-1){1'b0}}, ovf_q}; end
            OP_SAT16:    sr = clamp_half(ext_full(x2.a));
            OP_ADD16:    sr = clamp_half(ext_half(x2.a[HW-1:0]) + ext_half(x2.b[HW-1:0]));
            OP_SUB16:    sr = clamp_half(ext_half(x2.a[HW-1:0]) - ext_half(x2.b[HW-1:0]));
            OP_ADD32:    sr = clamp_full(ext_full(x2.a) + ext_full(x2.b));
            OP_SUB32:    sr = clamp_full(ext_full(x2.a) - ext_full(x2.b));
            OP_MUL16:    sr = clamp_half(ext_full(shr_prod));
            OP_MUL32:    sr = '{val: dbl_val, ovf: dbl_ovf};
            OP_MAC:      begin
                             sr = clamp_full(ext_full(x2.c) + ext_full(dbl_val));
                             hit = dbl_ovf;
                         end
            OP_MSU:      begin
                             sr = clamp_full(ext_full(x2.c) - ext_full(dbl_val));
                             hit = dbl_ovf;
                         end
            OP_CLR_FLAG: ovf_d = 1'b0;
            OP_SET_FLAG: ovf_d = 1'b1;
            default:     ;
        endcase
        if (x2.op inside {OP_SAT16, OP_ADD16, OP_SUB16, OP_ADD32, OP_SUB32,
                          OP_MUL16, OP_MUL32, OP_MAC, OP_MSU}) begin
            wb_en   = 1'b1;
            wb_data = sr.val;
            ovf_d   = ovf_q | sr.ovf | hit;
        end
        if (!x2.valid) begin
            wb_en = 1'b0;
            rd_en = 1'b0;
            ovf_d = ovf_q;
        end
    end
endmodule

// File: rtl/dspc_core.sv
module dspc_core
    import dspc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_op,
    input  logic [AW-1:0]  cmd_dst,
    input  logic [AW-1:0]  cmd_src_a,
    input  logic [AW-1:0]  cmd_src_b,
    input  logic [DW-1:0]  host_data,
    output logic           res_valid,
    output logic [DW-1:0]  res_data
);
    x1_t                   x1_d, x1_q;
    x2_t                   x2_d, x2_q;
    logic                  ovf_q, ovf_d;
    logic                  wb_en, rd_en;
    logic [DW-1:0]         wb_data, rd_data;
    logic [NRD-1:0][AW-1:0] raddr;
    logic [NRD-1:0][DW-1:0] rdata;
    logic                  res_valid_q;
    logic [DW-1:0]         res_data_q;
    logic                  x2_vld;
    op_e                   x2_op;
    op_e                   op_in;

    assign raddr = {cmd_dst, cmd_src_b, cmd_src_a};

    dspc_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD), .AW(AW)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_en),
        .waddr (x2_q.dst),
        .wdata (wb_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    always_comb begin
        op_in = cmd_valid ? op_e'(cmd_op) : OP_NOP;
        x1_d  = '{valid: cmd_valid, op: op_in, dst: cmd_dst,
                  src_a: cmd_src_a, src_b: cmd_src_b,
                  a: uses_host(op_in) ? host_data : rdata[0],
                  b: rdata[1], c: rdata[2]};
    end

    dspc_exec1 ex1_i (
        .x1       (x1_q),
        .fwd_en   (wb_en),
        .fwd_dst  (x2_q.dst),
        .fwd_data (wb_data),
        .x2       (x2_d)
    );

    dspc_exec2 ex2_i (
        .x2      (x2_q),
        .ovf_q   (ovf_q),
        .wb_en   (wb_en),
        .wb_data (wb_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .ovf_d   (ovf_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x1_q        <= '0;
            x2_q        <= '0;
            ovf_q       <= 1'b0;
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
        end else begin
            x1_q        <= x1_d;
            x2_q        <= x2_d;
            ovf_q       <= ovf_d;
            res_valid_q <= rd_en;
            res_data_q  <= rd_en ? rd_data : '0;
        end
    end

    assign res_valid = res_valid_q;
    assign res_data  = res_data_q;
    assign x2_vld    = x2_q.valid;
    assign x2_op     = x2_q.op;
endmodule

// File: rtl/dspc_core_chk.sv
module dspc_core_chk
    import dspc_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           cmd_valid,
    input logic [3:0]     cmd_op,
    input logic           res_valid,
    input logic [DW-1:0]  res_data,
    input logic           ovf_q,
    input logic           x2_vld,
    input op_e            x2_op
);
    logic is_read;
    assign is_read = cmd_valid && (cmd_op == OP_RD_REG || cmd_op == OP_RD_FLAG);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!res_valid && res_data == '0)); // R1

    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
        is_read |-> ##3 res_valid); // R2

    AST_FLAG_READ_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RD_FLAG) |-> ##3 (res_data[DW-1:1] == '0)); // R3

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        (!is_read) |-> ##3 !res_valid); // R12

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(x2_vld && (x2_op == OP_CLR_FLAG || x2_op == OP_WR_FLAG))) |=> ovf_q); // R10

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (x2_vld && x2_op == OP_CLR_FLAG) |=> !ovf_q); // R10
endmodule

bind dspc_core dspc_core_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .res_valid (res_valid),
    .res_data  (res_data),
    .ovf_q     (ovf_q),
    .x2_vld    (x2_vld),
    .x2_op     (x2_op)
);

// File: tb/dspc_core_tb_top.sv
module dspc_core_tb_top;
    localparam logic [3:0] C_NOP = 0, C_WRR = 1, C_RDR = 2, C_WRF = 3, C_RDF = 4,
                           C_SAT = 5, C_A16 = 6, C_S16 = 7, C_A32 = 8, C_S32 = 9,
                           C_M16 = 10, C_M32 = 11, C_MAC = 12, C_MSU = 13,
                           C_CLR = 14, C_SET = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0, cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
    logic [31:0] host_data = '0;
    logic        res_valid;
    logic [31:0] res_data;

    dspc_core dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
        .host_data(host_data), .res_valid(res_valid), .res_data(res_data)
    );

    always #5 clk = ~clk;

    int    n_chk = 0, n_fail = 0, wd_cnt = 0;
    bit    run_chk = 1'b0;
    string cur_req = "R1";

    logic [31:0] m_rf [16];
    bit          m_ovf;
    bit          ev [3];
    logic [31:0] ed [3];
    string       et [3];

    function automatic logic [31:0] cl16(longint v);
        if (v > 32767)  return 32'h0000_7FFF;
        if (v < -32768) return 32'hFFFF_8000;
        return 32'(v);
    endfunction
    function automatic bit ov16(longint v);
        return (v > 32767) || (v < -32768);
    endfunction
    function automatic logic [31:0] cl32(longint v);
        if (v > 64'sd2147483647)  return 32'h7FFF_FFFF;
        if (v < -64'sd2147483648) return 32'h8000_0000;
        return 32'(v);
    endfunction
    function automatic bit ov32(longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    task automatic model_step(output bit v, output logic [31:0] r);
        logic [31:0] ra, rb, rc, tv;
        longint a32, b32, c32, a16, b16, p, t;
        bit ov;
        ra = m_rf[cmd_src_a]; rb = m_rf[cmd_src_b]; rc = m_rf[cmd_dst];
        a32 = longint'($signed(ra)); b32 = longint'($signed(rb)); c32 = longint'($signed(rc));
        a16 = longint'($signed(ra[15:0])); b16 = longint'($signed(rb[15:0]));
        p = a16 * b16;
        v = 1'b0; r = '0; ov = 1'b0;
        case (cmd_op)
            C_WRR: m_rf[cmd_dst] = host_data;
            C_RDR: begin v = 1'b1; r = ra; end
            C_WRF: m_ovf = host_data[0];
            C_RDF: begin v = 1'b1; r = {31'b0, m_ovf}; end
            C_SAT: begin m_rf[cmd_dst] = cl16(a32); ov = ov16(a32); end
            C_A16: begin m_rf[cmd_dst] = cl16(a16 + b16); ov = ov16(a16 + b16); end
            C_S16: begin m_rf[cmd_dst] = cl16(a16 - b16); ov = ov16(a16 - b16); end
            C_A32: begin m_rf[cmd_dst] = cl32(a32 + b32); ov = ov32(a32 + b32); end
            C_S32: begin m_rf[cmd_dst] = cl32(a32 - b32); ov = ov32(a32 - b32); end
            C_M16: begin m_rf[cmd_dst] = cl16(p >>> 15); ov = ov16(p >>> 15); end
            C_M32: begin m_rf[cmd_dst] = cl32(2 * p); ov = ov32(2 * p); end
            C_MAC, C_MSU: begin
                tv = cl32(2 * p);
                t  = longint'($signed(tv));
                ov = ov32(2 * p);
                if (cmd_op == C_MAC) begin
                    m_rf[cmd_dst] = cl32(c32 + t); ov = ov | ov32(c32 + t);
                end else begin
                    m_rf[cmd_dst] = cl32(c32 - t); ov = ov | ov32(c32 - t);
                end
            end
            C_CLR: m_ovf = 1'b0;
            C_SET: m_ovf = 1'b1;
            default: ;
        endcase
        if (ov) m_ovf = 1'b1;
    endtask

    // reference model: sequential semantics, three-edge delay to the port
    always @(posedge clk) begin
        bit          nv;
        logic [31:0] nd;
        if (rst) begin
            for (int i = 0; i < 16; i++) m_rf[i] = '0;
            m_ovf = 1'b0;
            for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ed[i] = '0; et[i] = "R1"; end
        end else begin
            nv = 1'b0; nd = '0;
            if (cmd_valid) model_step(nv, nd);
            ev[2] = ev[1]; ed[2] = ed[1]; et[2] = et[1];
            ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
            ev[0] = nv;    ed[0] = nd;    et[0] = nv ? cur_req : "R12";
        end
    end

    task automatic report_end();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(negedge clk) begin
        if (run_chk) begin
            n_chk++;
            if (res_valid !== ev[2] || res_data !== ed[2]) begin
                n_fail++;
                $display("FAIL %s: valid/data actual %b/%h expected %b/%h",
                         et[2], res_valid, res_data, ev[2], ed[2]);
            end
        end
    end

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report_end();
        end
    end

    task automatic issue(input logic [3:0] op, input logic [3:0] d, input logic [3:0] sa,
                         input logic [3:0] sb, input logic [31:0] h);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_dst = d; cmd_src_a = sa; cmd_src_b = sb; host_data = h;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = C_NOP;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] d, input logic [31:0] h);
        issue(C_WRR, d, 4'd0, 4'd0, h);
    endtask
    task automatic rd(input logic [3:0] s);
        issue(C_RDR, 4'd0, s, 4'd0, 32'd0);
    endtask
    task automatic rdf();
        issue(C_RDF, 4'd0, 4'd0, 4'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_valid !== 1'b0 || res_data !== 32'd0) begin
            n_fail++;
            $display("FAIL R1: during reset actual %b/%h expected 0/00000000", res_valid, res_data);
        end
        rst = 1'b0;
        run_chk = 1'b1;

        cur_req = "R1";
        for (int i = 0; i < 16; i++) rd(4'(i));
        rdf();
        idle(4);

        cur_req = "R2";
        wr(1, 32'h1234_5678); wr(2, 32'hDEAD_BEEF); rd(1); rd(2); idle(4);

        cur_req = "R4";
        wr(3, 32'h0001_2345); issue(C_SAT, 4, 3, 0, 0); rd(4);
        wr(3, 32'hFFFF_0000); issue(C_SAT, 4, 3, 0, 0); rd(4);
        wr(3, 32'hFFFF_9234); issue(C_SAT, 4, 3, 0, 0); rd(4); idle(4);

        cur_req = "R5";
        wr(5, 32'h0000_7000); wr(6, 32'hABCD_7000); wr(8, 32'h0000_9000);
        issue(C_A16, 7, 5, 6, 0); rd(7);
        issue(C_S16, 7, 8, 5, 0); rd(7);
        issue(C_A16, 7, 5, 8, 0); rd(7); idle(4);

        cur_req = "R6";
        wr(9, 32'h7FFF_FFFF); wr(10, 32'd1); wr(12, 32'h8000_0000);
        issue(C_A32, 11, 9, 10, 0); rd(11);
        issue(C_S32, 11, 12, 10, 0); rd(11);
        issue(C_S32, 11, 10, 9, 0); rd(11); idle(4);

        cur_req = "R7";
        wr(1, 32'hFFFF_8000); wr(3, 32'h0000_4000); wr(4, 32'hFFFF_C000);
        issue(C_M16, 2, 1, 1, 0); rd(2);
        issue(C_M16, 5, 3, 4, 0); rd(5); idle(4);

        cur_req = "R8";
        issue(C_M32, 6, 1, 1, 0); rd(6);
        issue(C_M32, 7, 3, 4, 0); rd(7); idle(4);

        cur_req = "R9";
        wr(8, 32'h0000_0010); issue(C_MAC, 8, 3, 3, 0); rd(8);
        issue(C_MSU, 8, 3, 4, 0); rd(8);
        wr(9, 32'h7FFF_FFFF); issue(C_MAC, 9, 3, 3, 0); rd(9);
        wr(9, 32'h8000_0000); issue(C_MSU, 9, 1, 1, 0); rd(9); idle(4);

        cur_req = "R3";
        issue(C_WRF, 0, 0, 0, 32'hFFFF_FFFE); rdf();
        issue(C_WRF, 0, 0, 0, 32'h0000_0001); rdf(); idle(4);

        cur_req = "R10";
        issue(C_CLR, 0, 0, 0, 0); rdf();
        wr(9, 32'h7FFF_FFFF); issue(C_A32, 11, 9, 10, 0); rdf();
        issue(C_A32, 11, 10, 10, 0); rdf(); idle(2); rdf();
        issue(C_CLR, 0, 0, 0, 0); rdf();
        issue(C_SET, 0, 0, 0, 0); rdf(); idle(4);

        cur_req = "R11";
        wr(1, 32'd1);
        for (int i = 0; i < 8; i++) issue(C_A32, 1, 1, 1, 0);
        rd(1);
        wr(2, 32'h0000_0003); issue(C_M32, 3, 2, 2, 0); issue(C_MAC, 3, 3, 2, 0);
        issue(C_MSU, 3, 3, 3, 0); rd(3); issue(C_S16, 4, 3, 2, 0); rd(4); idle(4);
        for (int i = 0; i < 400; i++) begin
            issue(4'($urandom_range(0, 15)), 4'($urandom_range(0, 3)),
                  4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
                  ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFF0 + 32'($urandom_range(0, 31))
                                              : $urandom());
        end
        for (int i = 0; i < 4; i++) rd(4'(i));
        rdf();

        cur_req = "R12";
        idle(6);
        run_chk = 1'b0;
        report_end();
    end
endmodule